// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block is a register-mapped front end for a small embedded flash array. The array is held inside the block as a word memory of 64-bit entries. Software selects a target with a byte-address register and loads a 64-bit word through two 32-bit halves. Writing an opcode to the command register then starts a program, a page erase or a mass erase of one of the two banks. A busy bit is high while an operation runs, and a sticky done bit reports its end.

Programming follows flash physics. It can only pull bits low, so the stored word becomes the old contents ANDed with the new data. Only an erase brings bits back to one. Each word carries an 8-bit check code. With checking enabled, a second program of the same word leaves a code that no longer matches, and the read port reports an ECC error for that word. With checking disabled, a per-word program count catches any third program before an erase. Erase commands run only after the unlock key has been written. The key is cleared by every accepted command write.

Top module: `flash_pe_ctrl`

## Requirements
- R1: A program command stores (old word AND new data) at the word selected by the address register, with data bits 31:0 from the low data register (offset 0x08) and bits 63:32 from the high data register (offset 0x0C).
- R2: An operation starts only when an opcode is written to the command register (offset 0x00; 1 = program, 2 = page erase, 3 = erase bank 0, 4 = erase bank 1). Status bit 0 (busy) is high for exactly PROG_CYCLES cycles for a program, and status bit 2 (done) is set when the operation finishes.
- R3: A page erase sets every word of the page given by the page register (offset 0x14) to all ones, leaves other pages unchanged, and keeps busy high for ERASE_CYCLES cycles.
- R4: Opcode 3 sets every word of bank 0 (the lower half of the array) to all ones, and opcode 4 does the same for bank 1. Neither touches the other bank.
- R5: An erase opcode issued without UNLOCK_KEY in the key register (offset 0x10) leaves the array untouched, sets status bit 1 (key error) and done, and never raises busy. Any accepted command write clears the key, so a second erase needs the key again.
- R6: With control bit 0 (offset 0x1C, reset value 1) set, a word programmed once reads back with no ECC error, a word programmed a second time reads back with the ECC error flag set, and an erase clears that flag.
- R7: With control bit 0 cleared, a word may be programmed twice without any flag and with AND semantics. A third program before an erase sets status bit 4 (over-program).
- R8: Writes to the address, data, page or command registers while busy have no effect.
- R9: A program whose address is not a multiple of 8, or lies beyond the array, or a page erase whose page number is out of range, sets status bit 3 (address error) and done, leaves the array unchanged and never raises busy.
- R10: After reset the status register (offset 0x18) reads 0, the control register reads 1 and every array word reads all ones. Writing 1 to status bits 1 to 4 clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| fl_raddr | input | clog2(array bytes) | Byte address for the array read port |
| fl_rdata | output | 64 | Array word at fl_raddr (all ones if misaligned) |
| fl_ecc_err | output | 1 | Check-code mismatch on a programmed word at fl_raddr |

## Verification
The bench builds the block with 64-byte pages and two pages per bank. The whole array is then 32 words, so a page erase, both bank erases and their edges fall within a few addresses, and an out-of-range page number is simply 4. Program and erase times are shortened to 4 and 6 cycles. The bench checks the exact busy length and also lands writes inside the busy window, which is what the ignore rule concerns.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_PAGE  = 3'd2,
        OP_MASS0 = 3'd3,
        OP_MASS1 = 3'd4
    } op_e;

    localparam logic [4:0] REG_CMD  = 5'h00;
    localparam logic [4:0] REG_ADDR = 5'h04;
    localparam logic [4:0] REG_DLO  = 5'h08;
    localparam logic [4:0] REG_DHI  = 5'h0C;
    localparam logic [4:0] REG_KEY  = 5'h10;
    localparam logic [4:0] REG_PAGE = 5'h14;
    localparam logic [4:0] REG_STAT = 5'h18;
    localparam logic [4:0] REG_CTRL = 5'h1C;

    localparam int ST_KEYERR   = 1;
    localparam int ST_DONE     = 2;
    localparam int ST_ADDRERR  = 3;
    localparam int ST_OVERPROG = 4;

    // status word, bit 0 at the right
    typedef struct packed {
        logic overprog;
        logic addrerr;
        logic done;
        logic keyerr;
        logic busy;
    } status_t;

    // one-cycle set requests toward the status register
    typedef struct packed {
        logic done;
        logic keyerr;
        logic addrerr;
        logic overprog;
    } evt_t;

    // 8-bit check code: bit k is the parity of data bits with index mod 8 == k
    function automatic logic [7:0] ecc8(input logic [63:0] d);
        logic [7:0] e;
        e = '0;
        for (int j = 0; j < 64; j++) begin
            e[j[2:0]] = e[j[2:0]] ^ d[j];
        end
        return e;
    endfunction

    function automatic op_e decode_op(input logic [31:0] v);
        return (v < 32'd5) ? op_e'(v[2:0]) : OP_NONE;
    endfunction

endpackage

// File: rtl/flc_regs.sv
module flc_regs
    import flc_pkg::*;
#(
    parameter logic [31:0] UNLOCK_KEY = 32'h5EC2_4A7D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        busy,
    input  evt_t        evt,
    output logic        cmd_wr,
    output op_e         cmd_op,
    output logic [31:0] addr_q,
    output logic [31:0] page_q,
    output logic [63:0] data_q,
    output logic        key_ok,
    output logic        ecc_en
);

    logic [31:0] key_q;
    status_t     st;
    logic        w1c;
    logic        wr_idle;

    assign wr_idle = bus_we && !busy;
    assign cmd_wr  = wr_idle && (bus_addr == REG_CMD);
    assign cmd_op  = decode_op(bus_wdata);
    assign key_ok  = (key_q == UNLOCK_KEY);
    assign w1c     = bus_we && (bus_addr == REG_STAT);

    always_comb begin
        st      = '0;
        st.busy = busy;
    end

    logic f_keyerr, f_done, f_addrerr, f_overprog;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            page_q <= '0;
            data_q <= '0;
            key_q  <= '0;
            ecc_en <= 1'b1;
        end else begin
            if (wr_idle && bus_addr == REG_ADDR) addr_q        <= bus_wdata;
            if (wr_idle && bus_addr == REG_PAGE) page_q        <= bus_wdata;
            if (wr_idle && bus_addr == REG_DLO)  data_q[31:0]  <= bus_wdata;
            if (wr_idle && bus_addr == REG_DHI)  data_q[63:32] <= bus_wdata;
            if (bus_we && bus_addr == REG_CTRL)  ecc_en        <= bus_wdata[0];
            if (cmd_wr)
                key_q <= '0;
            else if (bus_we && bus_addr == REG_KEY)
                key_q <= bus_wdata;
        end
    end

    // sticky flags: a set request wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            f_keyerr   <= 1'b0;
            f_done     <= 1'b0;
            f_addrerr  <= 1'b0;
            f_overprog <= 1'b0;
        end else begin
            if (evt.keyerr)                        f_keyerr   <= 1'b1;
            else if (w1c && bus_wdata[ST_KEYERR])  f_keyerr   <= 1'b0;
            if (evt.done)                          f_done     <= 1'b1;
            else if (w1c && bus_wdata[ST_DONE])    f_done     <= 1'b0;
            if (evt.addrerr)                       f_addrerr  <= 1'b1;
            else if (w1c && bus_wdata[ST_ADDRERR]) f_addrerr  <= 1'b0;
            if (evt.overprog)                      f_overprog <= 1'b1;
            else if (w1c && bus_wdata[ST_OVERPROG]) f_overprog <= 1'b0;
        end
    end

    status_t st_rd;
    always_comb begin
        st_rd          = st;
        st_rd.keyerr   = f_keyerr;
        st_rd.done     = f_done;
        st_rd.addrerr  = f_addrerr;
        st_rd.overprog = f_overprog;
    end

    always_comb begin
        case (bus_addr)
            REG_ADDR: bus_rdata = addr_q;
            REG_DLO:  bus_rdata = data_q[31:0];
            REG_DHI:  bus_rdata = data_q[63:32];
            REG_PAGE: bus_rdata = page_q;
            REG_STAT: bus_rdata = {27'b0, st_rd};
            REG_CTRL: bus_rdata = {31'b0, ecc_en};
            default:  bus_rdata = '0;
        endcase
    end

    assert_addr_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && bus_addr == REG_ADDR) |=> $stable(addr_q));

    assert_key_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (key_q == '0));

    assert_done_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (w1c && bus_wdata[ST_DONE] && !evt.done) |=> !f_done);

endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int NUM_WORDS    = 1024,
    parameter int NUM_PAGES    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  op_e         cmd_op,
    input  logic [31:0] addr_q,
    input  logic [31:0] page_q,
    input  logic        key_ok,
    output logic        busy,
    output logic        go,
    output op_e         run_op,
    output logic        done_set,
    output logic        keyerr_set,
    output logic        addrerr_set
);

    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          is_erase, addr_bad, page_bad, start;

    assign is_erase = (cmd_op == OP_PAGE) || (cmd_op == OP_MASS0) || (cmd_op == OP_MASS1);
    assign addr_bad = (addr_q[2:0] != 3'b0) || (addr_q[31:3] >= 29'(NUM_WORDS));
    assign page_bad = (page_q >= 32'(NUM_PAGES));

    // checks happen at issue; a rejected command finishes at once
    assign keyerr_set  = cmd_wr && is_erase && !key_ok;
    assign addrerr_set = cmd_wr && !keyerr_set &&
                         (((cmd_op == OP_PROG) && addr_bad) || ((cmd_op == OP_PAGE) && page_bad));
    assign start       = cmd_wr && (cmd_op != OP_NONE) && !keyerr_set && !addrerr_set;
    assign go          = busy && (cnt == '0);
    assign done_set    = go || keyerr_set || addrerr_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            run_op <= OP_NONE;
        end else if (start) begin
            busy   <= 1'b1;
            run_op <= cmd_op;
            cnt    <= (cmd_op == OP_PROG) ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr));

    assert_keyerr_no_run_R5: assert property (@(posedge clk) disable iff (rst)
        keyerr_set |=> !busy);

    assert_addrerr_no_run_R9: assert property (@(posedge clk) disable iff (rst)
        addrerr_set |=> !busy);

endmodule

// File: rtl/flc_array.sv
module flc_array
    import flc_pkg::*;
#(
    parameter int NUM_WORDS      = 1024,
    parameter int WORDS_PER_PAGE = 256,
    parameter int WORDS_PER_BANK = 512,
    parameter int RAW            = 13
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         go,
    input  op_e                          run_op,
    input  logic [$clog2(NUM_WORDS)-1:0] prog_idx,
    input  logic [31:0]                  page_q,
    input  logic [63:0]                  wdata,
    input  logic                         ecc_en,
    input  logic [RAW-1:0]               rd_addr,
    output logic [63:0]                  rd_data,
    output logic                         rd_ecc_err,
    output logic                         overprog_set
);

    localparam int IW = $clog2(NUM_WORDS);

    logic [63:0]          mem    [NUM_WORDS];
    logic [7:0]           ecc_q  [NUM_WORDS];
    logic [1:0]           pcnt   [NUM_WORDS];
    logic [NUM_WORDS-1:0] ers_hit;
    logic [63:0]          new_word;
    logic                 do_prog;

    assign do_prog  = go && (run_op == OP_PROG);
    assign new_word = mem[prog_idx] & wdata;
    assign overprog_set = do_prog && !ecc_en && (pcnt[prog_idx] >= 2'd2);

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            case (run_op)
                OP_PAGE:  ers_hit[w] = (32'(w / WORDS_PER_PAGE) == page_q);
                OP_MASS0: ers_hit[w] = ((w / WORDS_PER_BANK) == 0);
                OP_MASS1: ers_hit[w] = ((w / WORDS_PER_BANK) == 1);
                default:  ers_hit[w] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                mem[w]   <= '1;
                ecc_q[w] <= ecc8('1);
                pcnt[w]  <= '0;
            end
        end else if (go) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (ers_hit[w]) begin
                    mem[w]   <= '1;
                    ecc_q[w] <= ecc8('1);
                    pcnt[w]  <= '0;
                end
            end
            if (run_op == OP_PROG) begin
                mem[prog_idx]   <= new_word;
                // a repeat program with checking on leaves a code that cannot match
                ecc_q[prog_idx] <= (ecc_en && pcnt[prog_idx] != 2'd0) ? ~ecc8(new_word)
                                                                      : ecc8(new_word);
                if (pcnt[prog_idx] != 2'd3) pcnt[prog_idx] <= pcnt[prog_idx] + 2'd1;
            end
        end
    end

    logic [IW-1:0] rd_idx;
    logic          rd_ok;
    assign rd_idx     = rd_addr[RAW-1:3];
    assign rd_ok      = (rd_addr[2:0] == 3'b0);
    assign rd_data    = rd_ok ? mem[rd_idx] : '1;
    assign rd_ecc_err = rd_ok && ecc_en && (pcnt[rd_idx] != 2'd0) &&
                        (ecc_q[rd_idx] != ecc8(mem[rd_idx]));

    logic [IW-1:0] pg_first;
    assign pg_first = IW'(page_q * 32'(WORDS_PER_PAGE));

    assert_prog_and_R1: assert property (@(posedge clk) disable iff (rst)
        do_prog |=> (mem[$past(prog_idx)] == ($past(mem[prog_idx]) & $past(wdata))));

    assert_page_ones_R3: assert property (@(posedge clk) disable iff (rst)
        (go && run_op == OP_PAGE) |=> (mem[$past(pg_first)] == '1));

    assert_overprog_eccoff_R7: assert property (@(posedge clk) disable iff (rst)
        overprog_set |=> (pcnt[$past(prog_idx)] == 2'd3));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flc_pkg::*;
#(
    parameter int          PAGE_BYTES     = 2048,
    parameter int          PAGES_PER_BANK = 2,
    parameter int          PROG_CYCLES    = 8,
    parameter int          ERASE_CYCLES   = 64,
    parameter logic [31:0] UNLOCK_KEY     = 32'h5EC2_4A7D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [$clog2(PAGE_BYTES*PAGES_PER_BANK*2)-1:0] fl_raddr,
    output logic [63:0] fl_rdata,
    output logic        fl_ecc_err
);

    localparam int WORDS_PER_PAGE = PAGE_BYTES / 8;
    localparam int WORDS_PER_BANK = WORDS_PER_PAGE * PAGES_PER_BANK;
    localparam int NUM_PAGES      = 2 * PAGES_PER_BANK;
    localparam int NUM_WORDS      = 2 * WORDS_PER_BANK;
    localparam int IW             = $clog2(NUM_WORDS);
    localparam int RAW            = $clog2(PAGE_BYTES * PAGES_PER_BANK * 2);

    logic        busy, go, cmd_wr, key_ok, ecc_en;
    op_e         cmd_op, run_op;
    logic [31:0] addr_q, page_q;
    logic [63:0] data_q;
    logic        done_set, keyerr_set, addrerr_set, overprog_set;
    evt_t        evt;

    always_comb begin
        evt.done     = done_set;
        evt.keyerr   = keyerr_set;
        evt.addrerr  = addrerr_set;
        evt.overprog = overprog_set;
    end

    flc_regs #(.UNLOCK_KEY(UNLOCK_KEY)) regs_i (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .evt(evt),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .addr_q(addr_q), .page_q(page_q), .data_q(data_q),
        .key_ok(key_ok), .ecc_en(ecc_en)
    );

    flc_seq #(
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
        .NUM_WORDS(NUM_WORDS), .NUM_PAGES(NUM_PAGES)
    ) seq_i (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .addr_q(addr_q), .page_q(page_q), .key_ok(key_ok),
        .busy(busy), .go(go), .run_op(run_op),
        .done_set(done_set), .keyerr_set(keyerr_set), .addrerr_set(addrerr_set)
    );

    flc_array #(
        .NUM_WORDS(NUM_WORDS), .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .WORDS_PER_BANK(WORDS_PER_BANK), .RAW(RAW)
    ) array_i (
        .clk(clk), .rst(rst),
        .go(go), .run_op(run_op),
        .prog_idx(addr_q[IW+2:3]), .page_q(page_q), .wdata(data_q),
        .ecc_en(ecc_en),
        .rd_addr(fl_raddr), .rd_data(fl_rdata), .rd_ecc_err(fl_ecc_err),
        .overprog_set(overprog_set)
    );

endmodule

// File: tb/flash_pe_ctrl_tb_top.sv
module flash_pe_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          PAGE_BYTES = 64;
    localparam int          PPB        = 2;
    localparam int          PROG_C     = 4;
    localparam int          ERASE_C    = 6;
    localparam logic [31:0] KEY        = 32'h5EC2_4A7D;
    localparam int          RAW        = 8;

    localparam logic [4:0] A_CMD = 5'h00, A_ADDR = 5'h04, A_DLO = 5'h08, A_DHI = 5'h0C,
                           A_KEY = 5'h10, A_PAGE = 5'h14, A_STAT = 5'h18, A_CTRL = 5'h1C;

    // program vectors: address, high data, low data, expected high, expected low, ECC error
    localparam int NV = 6;
    localparam logic [31:0] V_ADDR [NV] = '{32'h00, 32'h08, 32'h00, 32'h80, 32'hF8, 32'h40};
    localparam logic [31:0] V_DHI  [NV] = '{32'hFFFF0000, 32'hA5A5A5A5, 32'hF0F0FFFF,
                                            32'h00000000, 32'h13579BDF, 32'h0000FFFF};
    localparam logic [31:0] V_DLO  [NV] = '{32'h12345678, 32'h0F0F0F0F, 32'hFFFF00FF,
                                            32'hFFFFFFFE, 32'h2468ACE0, 32'hFFFF0000};
    localparam logic [31:0] V_EHI  [NV] = '{32'hFFFF0000, 32'hA5A5A5A5, 32'hF0F00000,
                                            32'h00000000, 32'h13579BDF, 32'h0000FFFF};
    localparam logic [31:0] V_ELO  [NV] = '{32'h12345678, 32'h0F0F0F0F, 32'h12340078,
                                            32'hFFFFFFFE, 32'h2468ACE0, 32'hFFFF0000};
    localparam logic        V_EERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_we = 1'b0;
    logic [4:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [RAW-1:0] fl_raddr = '0;
    logic [63:0]    fl_rdata;
    logic           fl_ecc_err;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BANK(PPB),
        .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C), .UNLOCK_KEY(KEY)
    ) dut_i (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_raddr(fl_raddr), .fl_rdata(fl_rdata), .fl_ecc_err(fl_ecc_err)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic frd(input logic [31:0] a, output logic [63:0] d, output logic e);
        fl_raddr = a[RAW-1:0];
        #1;
        d = fl_rdata;
        e = fl_ecc_err;
    endtask

    task automatic run_cmd(input logic [31:0] code, output int cyc, output logic [31:0] st);
        wr(A_STAT, 32'h1E);
        wr(A_CMD, code);
        cyc = 0;
        peek(A_STAT, st);
        while (st[0] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            peek(A_STAT, st);
        end
    endtask

    task automatic prog(input logic [31:0] a, input logic [31:0] hi, input logic [31:0] lo,
                        output int cyc, output logic [31:0] st);
        wr(A_ADDR, a);
        wr(A_DLO, lo);
        wr(A_DHI, hi);
        run_cmd(32'd1, cyc, st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] st, v;
        logic [63:0] d;
        logic        e;
        int          cyc;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        peek(A_STAT, v);  chk("R10 status after reset", v, 0);
        peek(A_CTRL, v);  chk("R10 control after reset", v, 1);
        frd(32'h00, d, e); chk("R10 word 0 erased", d, '1);
        frd(32'hF8, d, e); chk("R10 last word erased", d, '1);

        // R2 nothing starts before the command write
        wr(A_ADDR, 32'h18); wr(A_DLO, 0); wr(A_DHI, 0);
        @(negedge clk);
        peek(A_STAT, v);  chk("R2 no busy without command", v, 0);
        frd(32'h18, d, e); chk("R2 word untouched without command", d, '1);

        // R1 R2 R6 vector table
        for (int i = 0; i < NV; i++) begin
            prog(V_ADDR[i], V_DHI[i], V_DLO[i], cyc, st);
            chk("R2 program busy cycles", cyc, PROG_C);
            chk("R2 done and no error bits", st, 32'h4);
            frd(V_ADDR[i], d, e);
            chk("R1 programmed word", d, {V_EHI[i], V_ELO[i]});
            chk("R6 ECC flag after program", e, V_EERR[i]);
        end

        // R8 writes during busy are dropped
        wr(A_ADDR, 32'h20); wr(A_DLO, 0); wr(A_DHI, 0);
        wr(A_STAT, 32'h1E);
        wr(A_CMD, 1);
        wr(A_ADDR, 32'h28);
        wr(A_DLO, 32'h1);
        wr(A_CMD, 1);
        peek(A_STAT, st);
        while (st[0]) begin @(negedge clk); peek(A_STAT, st); end
        repeat (PROG_C + 2) @(negedge clk);
        peek(A_STAT, v);  chk("R8 no second run after busy", v[0], 0);
        peek(A_ADDR, v);  chk("R8 address kept during busy", v, 32'h20);
        frd(32'h20, d, e); chk("R8 data kept during busy", d, 0);
        frd(32'h28, d, e); chk("R8 second target untouched", d, '1);

        // R10 write one to clear done
        wr(A_STAT, 32'h4);
        peek(A_STAT, v);  chk("R10 done cleared by write one", v[2], 0);

        // R5 erase without key
        wr(A_PAGE, 0);
        run_cmd(2, cyc, st);
        chk("R5 rejected erase takes no busy", cyc, 0);
        chk("R5 key error and done", st, 32'h6);
        frd(32'h00, d, e); chk("R5 array untouched", d, 64'hF0F00000_12340078);

        // R3 page erase with key
        wr(A_KEY, KEY);
        run_cmd(2, cyc, st);
        chk("R3 erase busy cycles", cyc, ERASE_C);
        chk("R3 erase done no errors", st, 32'h4);
        frd(32'h00, d, e); chk("R3 page word 0 ones", d, '1);
        chk("R6 ECC flag cleared by erase", e, 0);
        frd(32'h38, d, e); chk("R3 page last word ones", d, '1);
        frd(32'h40, d, e); chk("R3 next page untouched", d, 64'h0000FFFF_FFFF0000);

        // R5 key cleared after a command
        run_cmd(2, cyc, st);
        chk("R5 key must be rewritten", st, 32'h6);

        // R6 program once after erase
        prog(32'h00, 32'h11112222, 32'h33334444, cyc, st);
        frd(32'h00, d, e);
        chk("R6 data after erase and program", d, 64'h11112222_33334444);
        chk("R6 no ECC error on first program", e, 0);

        // R4 bank erases
        wr(A_KEY, KEY);
        run_cmd(3, cyc, st);
        chk("R4 bank 0 erase busy cycles", cyc, ERASE_C);
        frd(32'h00, d, e); chk("R4 bank 0 word 0 ones", d, '1);
        frd(32'h78, d, e); chk("R4 bank 0 top word ones", d, '1);
        frd(32'h80, d, e); chk("R4 bank 1 untouched", d, 64'h00000000_FFFFFFFE);
        wr(A_KEY, KEY);
        run_cmd(4, cyc, st);
        frd(32'h80, d, e); chk("R4 bank 1 erased", d, '1);
        frd(32'hF8, d, e); chk("R4 bank 1 top word erased", d, '1);

        // R7 checking off, three programs of one word
        wr(A_CTRL, 0);
        prog(32'h10, 32'hFFFFFFFF, 32'h0000FFFF, cyc, st);
        chk("R7 first program no flag", st, 32'h4);
        prog(32'h10, 32'h00FF00FF, 32'hFFFFFFFF, cyc, st);
        chk("R7 second program no flag", st, 32'h4);
        frd(32'h10, d, e);
        chk("R7 AND after two programs", d, 64'h00FF00FF_0000FFFF);
        chk("R7 no ECC flag when checking off", e, 0);
        prog(32'h10, 32'hFFFFFFFF, 32'hFFFF0F0F, cyc, st);
        chk("R7 third program flagged", st, 32'h14);
        frd(32'h10, d, e);
        chk("R7 AND after third program", d, 64'h00FF00FF_00000F0F);

        // R9 address errors
        prog(32'h14, 0, 0, cyc, st);
        chk("R9 misaligned no busy", cyc, 0);
        chk("R9 misaligned error and done", st, 32'hC);
        frd(32'h10, d, e); chk("R9 array untouched", d, 64'h00FF00FF_00000F0F);
        prog(32'h100, 0, 0, cyc, st);
        chk("R9 beyond array error", st, 32'hC);
        wr(A_KEY, KEY);
        wr(A_PAGE, 4);
        run_cmd(2, cyc, st);
        chk("R9 page out of range error", st, 32'hC);
        frd(32'h10, d, e); chk("R9 array untouched by bad page", d, 64'h00FF00FF_00000F0F);

        finish_run();
    end

endmodule